// File: doc/BRIEF.md
# Pipeline Operand Forwarding and Hazard Control

This block holds the hazard logic of a five-stage in-order pipeline (fetch, decode, execute, memory, write-back) with eight general-purpose registers. It is purely combinational. It looks at the register fields and the write and load flags of the instructions held in the fetch/decode, decode/execute, execute/memory and memory/write-back boundary registers, and at a taken-jump signal from execute. From these it produces the operand-source selects for the two ALU inputs and the hold, bubble and flush controls for the pipeline registers and the PC.

Every instruction carries one register field at bits [25:23] and another at bits [22:20]. ALU operand A is read through the [25:23] field and operand B through the [22:20] field. An operand is taken from the youngest in-flight producer that writes the register it needs. A load in execute whose destination is read by the instruction in decode holds the front of the pipe for one cycle. Jumps are predicted not-taken. A jump that resolves as taken in execute flushes the two younger stages while the PC loads the forwarded target.

Top module: `hazard_unit`

## Requirements
- R1: With no register-write flag set anywhere and no taken jump, both operand selects are 0 (register file) and every hold, bubble and flush output is 0. Select code 3 is never produced.
- R2: When the execute/memory instruction writes a register equal to the operand's field in execute, that operand's select is 1. Operand A uses the [25:23] field and operand B uses the [22:20] field.
- R3: When only the memory/write-back instruction writes the operand's register, the select is 2.
- R4: When both the execute/memory and the memory/write-back instructions write the operand's register, the select is 1, because the younger producer wins.
- R5: A matching destination does not count when that stage's register-write flag is 0. The select then falls through to the next stage, or to 0.
- R6: If the execute instruction is a load (load flag and write flag both set) and its destination equals either register field of the decode instruction, then PC hold, fetch/decode hold and decode/execute bubble are all 1 and both flushes are 0.
- R7: No stall occurs when a load's destination matches neither decode field, or when a matching execute instruction is not a load.
- R8: A taken jump in execute sets both the fetch/decode flush and the decode/execute flush.
- R9: A taken jump overrides a load-use match: hold and bubble stay 0 while both flushes are 1. Forwarding selects are not changed by stall or flush.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| id_fa | input | 3 | Decode instruction, field [25:23] |
| id_fb | input | 3 | Decode instruction, field [22:20] |
| ex_fa | input | 3 | Execute instruction, field [25:23] (operand A register) |
| ex_fb | input | 3 | Execute instruction, field [22:20] (operand B register) |
| ex_dst | input | 3 | Execute instruction destination |
| ex_wr | input | 1 | Execute instruction writes a register |
| ex_load | input | 1 | Execute instruction reads data memory |
| ex_jump_taken | input | 1 | Jump in execute resolved taken |
| mem_dst | input | 3 | Execute/memory instruction destination |
| mem_wr | input | 1 | Execute/memory instruction writes a register |
| wb_dst | input | 3 | Memory/write-back instruction destination |
| wb_wr | input | 1 | Memory/write-back instruction writes a register |
| fwd_a | output | 2 | Operand A source: 0 reg file, 1 exec/mem, 2 mem/wb |
| fwd_b | output | 2 | Operand B source, same coding |
| pc_hold | output | 1 | PC keeps its value |
| ifid_hold | output | 1 | Fetch/decode register keeps its value |
| idex_bubble | output | 1 | Decode/execute loads an all-zero-control NOP |
| ifid_flush | output | 1 | Fetch/decode register cleared to NOP |
| idex_flush | output | 1 | Decode/execute register cleared to NOP |

## Verification
The bench targets the case where both later stages write the same register. A design with the priority reversed would hand the ALU a stale value from the older producer. It also checks matches whose write flag is clear, which a careless design would still forward or stall on. Both decode fields are tried against a load destination; checking only one field would miss half the load-use cases. Finally, a taken jump is applied together with a load-use match, where a stall winning would freeze the PC and lose the jump target.

// File: rtl/hazard_pkg.sv
package hazard_pkg;

    typedef enum logic [1:0] {
        SRC_RF    = 2'd0,
        SRC_EXMEM = 2'd1,
        SRC_MEMWB = 2'd2
    } opnd_src_e;

    typedef struct packed {
        logic pc_hold;
        logic ifid_hold;
        logic idex_bubble;
        logic ifid_flush;
        logic idex_flush;
    } pipe_ctl_t;

endpackage

// File: rtl/operand_fwd_sel.sv
module operand_fwd_sel
    import hazard_pkg::*;
#(
    parameter int RW = 3
) (
    input  logic [RW-1:0] need_reg,
    input  logic          exmem_wr,
    input  logic [RW-1:0] exmem_dst,
    input  logic          memwb_wr,
    input  logic [RW-1:0] memwb_dst,
    output opnd_src_e     sel
);

    opnd_src_e sel_d;

    always_comb begin
        sel_d = SRC_RF;
        if (memwb_wr && (memwb_dst == need_reg)) sel_d = SRC_MEMWB;
        if (exmem_wr && (exmem_dst == need_reg)) sel_d = SRC_EXMEM;
    end

    assign sel = sel_d;

    // a_r5_*: a forwarding select must be backed by a set write flag
    always_comb begin
        a_r5_exmem_needs_wr: assert (sel != SRC_EXMEM || exmem_wr)
            else $error("exec/mem forward without write flag");
        a_r5_memwb_needs_wr: assert (sel != SRC_MEMWB || memwb_wr)
            else $error("mem/wb forward without write flag");
    end

endmodule

// File: rtl/load_use_detect.sv
module load_use_detect #(
    parameter int RW = 3
) (
    input  logic [RW-1:0] id_fa,
    input  logic [RW-1:0] id_fb,
    input  logic [RW-1:0] ex_dst,
    input  logic          ex_wr,
    input  logic          ex_load,
    output logic          hit
);

    logic hit_d;

    always_comb begin
        hit_d = 1'b0;
        if (ex_load && ex_wr)
            hit_d = (ex_dst == id_fa) || (ex_dst == id_fb);
    end

    assign hit = hit_d;

    always_comb begin
        a_r7_hit_needs_load: assert (!hit || ex_load)
            else $error("load-use hit without a load");
    end

endmodule

// File: rtl/redirect_ctrl.sv
module redirect_ctrl
    import hazard_pkg::*;
(
    input  logic      load_hit,
    input  logic      jump_taken,
    output pipe_ctl_t ctl
);

    pipe_ctl_t ctl_d;

    always_comb begin
        ctl_d = '0;
        if (jump_taken) begin
            ctl_d.ifid_flush = 1'b1;
            ctl_d.idex_flush = 1'b1;
        end else if (load_hit) begin
            ctl_d.pc_hold     = 1'b1;
            ctl_d.ifid_hold   = 1'b1;
            ctl_d.idex_bubble = 1'b1;
        end
    end

    assign ctl = ctl_d;

    always_comb begin
        a_r9_flush_excludes_hold: assert (!(ctl.ifid_flush && ctl.pc_hold))
            else $error("hold and flush together");
        a_r8_flush_pair: assert (ctl.ifid_flush == ctl.idex_flush)
            else $error("flushes disagree");
        a_r6_stall_pair: assert (ctl.pc_hold == ctl.idex_bubble)
            else $error("hold without bubble");
    end

endmodule

// File: rtl/hazard_unit.sv
module hazard_unit
    import hazard_pkg::*;
#(
    parameter int NREG = 8,
    localparam int RW  = $clog2(NREG)
) (
    input  logic [RW-1:0] id_fa,
    input  logic [RW-1:0] id_fb,
    input  logic [RW-1:0] ex_fa,
    input  logic [RW-1:0] ex_fb,
    input  logic [RW-1:0] ex_dst,
    input  logic          ex_wr,
    input  logic          ex_load,
    input  logic          ex_jump_taken,
    input  logic [RW-1:0] mem_dst,
    input  logic          mem_wr,
    input  logic [RW-1:0] wb_dst,
    input  logic          wb_wr,
    output logic [1:0]    fwd_a,
    output logic [1:0]    fwd_b,
    output logic          pc_hold,
    output logic          ifid_hold,
    output logic          idex_bubble,
    output logic          ifid_flush,
    output logic          idex_flush
);

    localparam int NOPND = 2;

    logic [RW-1:0] opnd_reg [NOPND];
    opnd_src_e     opnd_sel [NOPND];
    logic          load_hit;
    pipe_ctl_t     ctl;

    assign opnd_reg[0] = ex_fa;
    assign opnd_reg[1] = ex_fb;

    for (genvar g = 0; g < NOPND; g++) begin : g_opnd
        operand_fwd_sel #(.RW(RW)) u_sel (
            .need_reg  (opnd_reg[g]),
            .exmem_wr  (mem_wr),
            .exmem_dst (mem_dst),
            .memwb_wr  (wb_wr),
            .memwb_dst (wb_dst),
            .sel       (opnd_sel[g])
        );
    end

    load_use_detect #(.RW(RW)) u_lu (
        .id_fa   (id_fa),
        .id_fb   (id_fb),
        .ex_dst  (ex_dst),
        .ex_wr   (ex_wr),
        .ex_load (ex_load),
        .hit     (load_hit)
    );

    redirect_ctrl u_redir (
        .load_hit   (load_hit),
        .jump_taken (ex_jump_taken),
        .ctl        (ctl)
    );

    assign fwd_a       = opnd_sel[0];
    assign fwd_b       = opnd_sel[1];
    assign pc_hold     = ctl.pc_hold;
    assign ifid_hold   = ctl.ifid_hold;
    assign idex_bubble = ctl.idex_bubble;
    assign ifid_flush  = ctl.ifid_flush;
    assign idex_flush  = ctl.idex_flush;

    always_comb begin
        a_r1_sel_legal: assert (fwd_a != 2'd3 && fwd_b != 2'd3)
            else $error("illegal select code");
        a_r9_jump_wins: assert (!ex_jump_taken || (ifid_flush && !pc_hold))
            else $error("taken jump did not flush");
        a_r4_exmem_priority: assert (!(mem_wr && mem_dst == ex_fa) || fwd_a == 2'd1)
            else $error("older producer chosen for operand A");
    end

endmodule

// File: tb/hazard_unit_test.sv
module hazard_unit_test;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic [2:0] id_fa, id_fb, ex_fa, ex_fb, ex_dst, mem_dst, wb_dst;
    logic ex_wr, ex_load, ex_jump_taken, mem_wr, wb_wr;
    logic [1:0] fwd_a, fwd_b;
    logic pc_hold, ifid_hold, idex_bubble, ifid_flush, idex_flush;

    int checks = 0;
    int errors = 0;

    hazard_unit uut (
        .id_fa(id_fa), .id_fb(id_fb), .ex_fa(ex_fa), .ex_fb(ex_fb),
        .ex_dst(ex_dst), .ex_wr(ex_wr), .ex_load(ex_load),
        .ex_jump_taken(ex_jump_taken), .mem_dst(mem_dst), .mem_wr(mem_wr),
        .wb_dst(wb_dst), .wb_wr(wb_wr), .fwd_a(fwd_a), .fwd_b(fwd_b),
        .pc_hold(pc_hold), .ifid_hold(ifid_hold), .idex_bubble(idex_bubble),
        .ifid_flush(ifid_flush), .idex_flush(idex_flush)
    );

    task automatic idle();
        @(negedge clk);
        id_fa = 3'd0; id_fb = 3'd0; ex_fa = 3'd0; ex_fb = 3'd0;
        ex_dst = 3'd0; mem_dst = 3'd0; wb_dst = 3'd0;
        ex_wr = 0; ex_load = 0; ex_jump_taken = 0; mem_wr = 0; wb_wr = 0;
    endtask

    // expected vector: {fwd_a, fwd_b, pc_hold, ifid_hold, idex_bubble, ifid_flush, idex_flush}
    task automatic expect_out(string req, logic [8:0] exp);
        logic [8:0] got;
        #5;
        got = {fwd_a, fwd_b, pc_hold, ifid_hold, idex_bubble, ifid_flush, idex_flush};
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %b expected %b", req, got, exp);
        end
    endtask

    task automatic t_r1_quiet();
        idle();
        ex_fa = 3'd4; ex_fb = 3'd4; mem_dst = 3'd4; wb_dst = 3'd4; ex_dst = 3'd4;
        id_fa = 3'd4;
        expect_out("R1", 9'b00_00_000_00);
    endtask

    task automatic t_r2_exmem();
        idle();
        ex_fa = 3'd3; ex_fb = 3'd5; mem_wr = 1; mem_dst = 3'd3;
        expect_out("R2 operand A", 9'b01_00_000_00);
        idle();
        ex_fa = 3'd1; ex_fb = 3'd6; mem_wr = 1; mem_dst = 3'd6;
        expect_out("R2 operand B", 9'b00_01_000_00);
    endtask

    task automatic t_r3_memwb();
        idle();
        ex_fa = 3'd2; ex_fb = 3'd7; wb_wr = 1; wb_dst = 3'd2;
        expect_out("R3 operand A", 9'b10_00_000_00);
        idle();
        ex_fa = 3'd5; ex_fb = 3'd5; wb_wr = 1; wb_dst = 3'd5;
        mem_wr = 1; mem_dst = 3'd1;
        expect_out("R3 both operands", 9'b10_10_000_00);
    endtask

    task automatic t_r4_priority();
        idle();
        ex_fa = 3'd4; ex_fb = 3'd4; mem_wr = 1; mem_dst = 3'd4;
        wb_wr = 1; wb_dst = 3'd4;
        expect_out("R4 younger wins", 9'b01_01_000_00);
        idle();
        ex_fa = 3'd7; ex_fb = 3'd0; mem_wr = 1; mem_dst = 3'd0;
        wb_wr = 1; wb_dst = 3'd7;
        expect_out("R4 split sources", 9'b10_01_000_00);
    endtask

    task automatic t_r5_gate();
        idle();
        ex_fa = 3'd4; ex_fb = 3'd2; mem_wr = 0; mem_dst = 3'd4;
        wb_wr = 1; wb_dst = 3'd4;
        expect_out("R5 fall through", 9'b10_00_000_00);
        idle();
        ex_fa = 3'd6; ex_fb = 3'd6; mem_dst = 3'd6; wb_dst = 3'd6;
        expect_out("R5 no flags", 9'b00_00_000_00);
    endtask

    task automatic t_r6_load_use();
        idle();
        ex_load = 1; ex_wr = 1; ex_dst = 3'd7; id_fa = 3'd7; id_fb = 3'd1;
        expect_out("R6 field A", 9'b00_00_111_00);
        idle();
        ex_load = 1; ex_wr = 1; ex_dst = 3'd3; id_fa = 3'd0; id_fb = 3'd3;
        expect_out("R6 field B", 9'b00_00_111_00);
    endtask

    task automatic t_r7_no_stall();
        idle();
        ex_load = 1; ex_wr = 1; ex_dst = 3'd7; id_fa = 3'd1; id_fb = 3'd2;
        expect_out("R7 no match", 9'b00_00_000_00);
        idle();
        ex_load = 0; ex_wr = 1; ex_dst = 3'd2; id_fa = 3'd2; id_fb = 3'd2;
        expect_out("R7 not a load", 9'b00_00_000_00);
    endtask

    task automatic t_r8_jump();
        idle();
        ex_jump_taken = 1;
        expect_out("R8 taken jump", 9'b00_00_000_11);
    endtask

    task automatic t_r9_jump_over_stall();
        idle();
        ex_jump_taken = 1; ex_load = 1; ex_wr = 1; ex_dst = 3'd5; id_fa = 3'd5;
        ex_fa = 3'd3; mem_wr = 1; mem_dst = 3'd3;
        expect_out("R9 jump overrides", 9'b01_00_000_11);
    endtask

    initial begin
        idle();
        expect_out("R1 start", 9'b00_00_000_00);
        t_r1_quiet();
        t_r2_exmem();
        t_r3_memwb();
        t_r4_priority();
        t_r5_gate();
        t_r6_load_use();
        t_r7_no_stall();
        t_r8_jump();
        t_r9_jump_over_stall();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog got timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule